// File: doc/BRIEF.md
# Mode-Gated System Configuration Register

This block holds the configuration word of a supply-and-transceiver controller. A host talks to it through 16-bit frames that an upstream serial shifter has already assembled; the block sees each frame as one word plus a one-cycle valid strobe. The two top bits of the frame name the target register. The next bit picks which of two feedback words is returned. The bit after that decides whether the frame is only a read or a read plus a write. The lower bits carry the configuration fields.

Frames are honoured only while the controller's operating mode is Normal or Standby. Outside those modes a frame is ignored. Some fields are forced regardless of the host. Entering the Reset mode sets the long reset length. Fail-safe mode, a falling edge on the external reset pin, or a short on the switched supply clears the two-bit supply control field. Every field is driven out on its own pin. The whole stored word and a registered readback word are driven out as well.

Top module: `sysconf_reg`

## Requirements
- R1: After power-on reset the stored word `cfg_word` is 16'h0100: only the reset-length bit (bit 8) is 1. `rd_vld` is 0 and `rd_data` is 0.
- R2: A frame is taken only when `frm_data[15:14]` equals 2'b10. Any other address leaves `cfg_word` unchanged and produces no `rd_vld` pulse.
- R3: A frame is taken only while `mode` is Normal (3'd1) or Standby (3'd2). In Reset (3'd0), Sleep (3'd3), Fail-safe (3'd4) or any other code, a frame leaves the stored word unchanged, apart from the forcing of R8/R9, and produces no `rd_vld`.
- R4: A taken frame with bit 12 = 0 writes the frame's configuration bits into `cfg_word`. The new value is visible on the clock edge that samples the strobe.
- R5: A taken frame with bit 12 = 1 leaves `cfg_word` unchanged but still produces the readback.
- R6: For every taken frame, `rd_vld` is high for exactly the one cycle after the strobe. `rd_data` then holds `gp_fb` as sampled with the strobe if bit 13 = 1. If bit 13 = 0, it holds `cfg_word` as it was before that frame's write.
- R7: Bits 15:10 and bit 1 of `cfg_word` are always 0, whatever a frame writes.
- R8: When `mode` changes to Reset (3'd0), bit 8 (`rst_len_long`) is 1 from the next clock on.
- R9: Bits 7:6 (`sup_ctl`) become 00 on the next clock when `mode` is Fail-safe (3'd4), or `rstpin_fall` is pulsed, or `sup_short` is pulsed. This clearing wins over a write in the same cycle. The other written fields still take the frame's values.
- R10: The field outputs follow fixed bits of `cfg_word`: `gnd_thr_hi` bit 9, `rst_len_long` bit 8, `sup_ctl` bits 7:6, `uv_reduced` bit 5, `curmon_rst_en` bit 4, `wake_en` bit 3, `wake_cyclic` bit 2, `inh_high` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current operating mode code |
| frm_vld | input | 1 | One-cycle strobe: a complete frame is on `frm_data` |
| frm_data | input | 16 | Received frame word |
| gp_fb | input | 16 | General-purpose feedback word for readback |
| rstpin_fall | input | 1 | Pulse: falling edge seen on the external reset pin |
| sup_short | input | 1 | Pulse: short circuit detected on the switched supply |
| cfg_word | output | 16 | Stored configuration word |
| gnd_thr_hi | output | 1 | Higher ground-shift threshold selected |
| rst_len_long | output | 1 | Long system reset length selected |
| sup_ctl | output | 2 | Switched-supply control field |
| uv_reduced | output | 1 | Reduced undervoltage threshold selected |
| curmon_rst_en | output | 1 | Current rise raises a reset event |
| wake_en | output | 1 | Wake input enabled |
| wake_cyclic | output | 1 | Wake input sampled cyclically |
| inh_high | output | 1 | Inhibit output driven high |
| rd_vld | output | 1 | One-cycle pulse: new readback word available |
| rd_data | output | 16 | Readback word |

## Verification
A host write and a forcing event can land on the same clock edge, and the forcing must win only over the field it owns. The bench provokes this in Normal mode. It sends a write frame that sets both supply-control bits and every other field. In the same cycle it pulses `sup_short`, then repeats with `rstpin_fall`. The check is that `sup_ctl` reads 00 while the rest of the word takes the frame's values. The readback of that frame must still show the word held before the write.

// File: rtl/sysconf_pkg.sv
package sysconf_pkg;

    localparam int FRAME_W  = 16;
    localparam int MODE_W   = 3;

    // frame control positions
    localparam int ADDR_HI   = 15;
    localparam int ADDR_LO   = 14;
    localparam int RSEL_BIT  = 13;
    localparam int RONLY_BIT = 12;

    // configuration field positions (decoded by neighbouring logic)
    localparam int GTH_BIT   = 9;
    localparam int RLEN_BIT  = 8;
    localparam int SUP_HI    = 7;
    localparam int SUP_LO    = 6;
    localparam int UVR_BIT   = 5;
    localparam int CMON_BIT  = 4;
    localparam int WEN_BIT   = 3;
    localparam int WCYC_BIT  = 2;
    localparam int INH_BIT   = 0;

    localparam logic [ADDR_HI-ADDR_LO:0] ADDR_SELF = 2'b10;

    // bits that may hold a 1; reserved positions are 0 here
    localparam logic [FRAME_W-1:0] WR_MASK  = 16'h03FD;
    localparam logic [FRAME_W-1:0] RST_WORD = 16'h0100;

    typedef enum logic [MODE_W-1:0] {
        MD_RESET    = 3'd0,
        MD_NORMAL   = 3'd1,
        MD_STANDBY  = 3'd2,
        MD_SLEEP    = 3'd3,
        MD_FAILSAFE = 3'd4
    } mode_e;

    typedef struct packed {
        logic take;   // frame accepted
        logic wr;     // frame also writes
        logic rsel;   // 1: general-purpose feedback, 0: configuration
    } frame_cmd_t;

    typedef struct packed {
        logic set_rlen;
        logic clr_sup;
    } force_t;

endpackage

// File: rtl/sysconf_frame_dec.sv
module sysconf_frame_dec
    import sysconf_pkg::*;
#(
    parameter int W      = FRAME_W,
    parameter int MW     = MODE_W
) (
    input  logic          frm_vld,
    input  logic [W-1:0]  frm_data,
    input  logic [MW-1:0] mode,
    output frame_cmd_t    cmd
);

    logic mode_ok;
    logic addr_ok;

    always_comb begin
        mode_ok  = (mode == MD_NORMAL) || (mode == MD_STANDBY);
        addr_ok  = (frm_data[ADDR_HI:ADDR_LO] == ADDR_SELF);
        cmd.take = frm_vld && mode_ok && addr_ok;
        cmd.wr   = cmd.take && !frm_data[RONLY_BIT];
        cmd.rsel = frm_data[RSEL_BIT];
    end

endmodule

// File: rtl/sysconf_force.sv
module sysconf_force
    import sysconf_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode,
    input  logic          rstpin_fall,
    input  logic          sup_short,
    output force_t        frc
);

    typedef struct packed {
        logic [MW-1:0] prev_mode;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.prev_mode = mode;
        frc.set_rlen   = (mode == MD_RESET) && (st_q.prev_mode != MD_RESET);
        frc.clr_sup    = (mode == MD_FAILSAFE) || rstpin_fall || sup_short;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_mode: MD_RESET};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sysconf_store.sv
module sysconf_store
    import sysconf_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  frame_cmd_t   cmd,
    input  logic [W-1:0] frm_data,
    input  force_t       frc,
    output logic [W-1:0] cfg_q
);

    typedef struct packed {
        logic [W-1:0] cfg;
    } sstate_t;

    sstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.wr)
            st_d.cfg = frm_data;
        if (frc.clr_sup)
            st_d.cfg[SUP_HI:SUP_LO] = '0;
        if (frc.set_rlen)
            st_d.cfg[RLEN_BIT] = 1'b1;
        st_d.cfg = st_d.cfg & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: RST_WORD};
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

endmodule

// File: rtl/sysconf_rdpath.sv
module sysconf_rdpath
    import sysconf_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  frame_cmd_t   cmd,
    input  logic [W-1:0] gp_fb,
    input  logic [W-1:0] cfg_q,
    output logic         rd_vld,
    output logic [W-1:0] rd_data
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } rstate_t;

    rstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = cmd.take;
        if (cmd.take)
            st_d.data = cmd.rsel ? gp_fb : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld  = st_q.vld;
    assign rd_data = st_q.data;

endmodule

// File: rtl/sysconf_reg.sv
module sysconf_reg
    import sysconf_pkg::*;
#(
    parameter int W  = FRAME_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode,
    input  logic          frm_vld,
    input  logic [W-1:0]  frm_data,
    input  logic [W-1:0]  gp_fb,
    input  logic          rstpin_fall,
    input  logic          sup_short,
    output logic [W-1:0]  cfg_word,
    output logic          gnd_thr_hi,
    output logic          rst_len_long,
    output logic [1:0]    sup_ctl,
    output logic          uv_reduced,
    output logic          curmon_rst_en,
    output logic          wake_en,
    output logic          wake_cyclic,
    output logic          inh_high,
    output logic          rd_vld,
    output logic [W-1:0]  rd_data
);

    frame_cmd_t   cmd;
    force_t       frc;
    logic [W-1:0] cfg_q;

    sysconf_frame_dec #(.W(W), .MW(MW)) u_dec (
        .frm_vld  (frm_vld),
        .frm_data (frm_data),
        .mode     (mode),
        .cmd      (cmd)
    );

    sysconf_force #(.MW(MW)) u_force (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .rstpin_fall (rstpin_fall),
        .sup_short   (sup_short),
        .frc         (frc)
    );

    sysconf_store #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .frm_data (frm_data),
        .frc      (frc),
        .cfg_q    (cfg_q)
    );

    sysconf_rdpath #(.W(W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .gp_fb   (gp_fb),
        .cfg_q   (cfg_q),
        .rd_vld  (rd_vld),
        .rd_data (rd_data)
    );

    always_comb begin
        cfg_word      = cfg_q;
        gnd_thr_hi    = cfg_q[GTH_BIT];
        rst_len_long  = cfg_q[RLEN_BIT];
        sup_ctl       = cfg_q[SUP_HI:SUP_LO];
        uv_reduced    = cfg_q[UVR_BIT];
        curmon_rst_en = cfg_q[CMON_BIT];
        wake_en       = cfg_q[WEN_BIT];
        wake_cyclic   = cfg_q[WCYC_BIT];
        inh_high      = cfg_q[INH_BIT];
    end

endmodule

// File: rtl/sysconf_reg_chk.sv
module sysconf_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode,
    input logic        frm_vld,
    input logic [15:0] frm_data,
    input logic        rstpin_fall,
    input logic        sup_short,
    input logic [15:0] cfg_word,
    input logic        rd_vld
);

    logic mode_ok, addr_ok, quiet;
    assign mode_ok = (mode == 3'd1) || (mode == 3'd2);
    assign addr_ok = (frm_data[15:14] == 2'b10);
    assign quiet   = !rstpin_fall && !sup_short;

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[15:10] == 6'd0) && !cfg_word[1]);

    // R2
    addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !addr_ok) |=> !rd_vld);

    // R3
    mode_gate_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !mode_ok) |=> !rd_vld);

    // R3
    mode_gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !mode_ok && quiet && mode != 3'd0 && mode != 3'd4)
        |=> $stable(cfg_word));

    // R5
    read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && mode_ok && addr_ok && frm_data[12] && quiet)
        |=> ($stable(cfg_word) && rd_vld));

    // R4
    write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && mode_ok && addr_ok && !frm_data[12])
        |=> (cfg_word[9:8] == $past(frm_data[9:8]) &&
             cfg_word[5:2] == $past(frm_data[5:2]) &&
             cfg_word[0]   == $past(frm_data[0])));

    // R9
    sup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_short || rstpin_fall || mode == 3'd4) |=> (cfg_word[7:6] == 2'b00));

    // R8
    rlen_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> cfg_word[8]);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !(frm_vld && mode_ok && addr_ok)) |=> !rd_vld);

endmodule

bind sysconf_reg sysconf_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .frm_vld     (frm_vld),
    .frm_data    (frm_data),
    .rstpin_fall (rstpin_fall),
    .sup_short   (sup_short),
    .cfg_word    (cfg_word),
    .rd_vld      (rd_vld)
);

// File: tb/sysconf_reg_bench.sv
module sysconf_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd1;
    logic        frm_vld = 1'b0;
    logic [15:0] frm_data = '0;
    logic [15:0] gp_fb = 16'h5A3C;
    logic        rstpin_fall = 1'b0;
    logic        sup_short = 1'b0;
    logic [15:0] cfg_word;
    logic        gnd_thr_hi, rst_len_long, uv_reduced, curmon_rst_en;
    logic        wake_en, wake_cyclic, inh_high, rd_vld;
    logic [1:0]  sup_ctl;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_cfg;

    always #5 clk = ~clk;

    sysconf_reg u_sysconf_reg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frm_vld(frm_vld),
        .frm_data(frm_data), .gp_fb(gp_fb), .rstpin_fall(rstpin_fall),
        .sup_short(sup_short), .cfg_word(cfg_word), .gnd_thr_hi(gnd_thr_hi),
        .rst_len_long(rst_len_long), .sup_ctl(sup_ctl), .uv_reduced(uv_reduced),
        .curmon_rst_en(curmon_rst_en), .wake_en(wake_en),
        .wake_cyclic(wake_cyclic), .inh_high(inh_high), .rd_vld(rd_vld),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // frame driven for one cycle, then sampled after the capturing edge
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        frm_vld  = 1'b1;
        frm_data = w;
        @(negedge clk);
        frm_vld  = 1'b0;
        frm_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 cfg_word", cfg_word, 16'h0100);
        chk("R1 rd_vld", {15'd0, rd_vld}, 16'd0);
        chk("R1 rd_data", rd_data, 16'd0);
    endtask

    task automatic t_write;
        mode = 3'd1;
        send(16'h8000 | 16'h0235);          // bits 9,5,4,2,0
        exp_cfg = 16'h0235;
        chk("R4 write normal", cfg_word, exp_cfg);
        chk("R10 fields", {6'd0, gnd_thr_hi, rst_len_long, sup_ctl, uv_reduced,
                           curmon_rst_en, wake_en, wake_cyclic, 1'b0, inh_high},
            exp_cfg);
        chk("R6 rd_data pre-write", rd_data, 16'h0100);
        chk("R6 rd_vld high", {15'd0, rd_vld}, 16'd1);
        @(negedge clk);
        chk("R6 rd_vld one cycle", {15'd0, rd_vld}, 16'd0);
        mode = 3'd2;
        send(16'h8000 | 16'h01C8);
        exp_cfg = 16'h01C8;
        chk("R4 write standby", cfg_word, exp_cfg);
    endtask

    task automatic t_reserved;
        mode = 3'd1;
        send(16'h8FFF);
        exp_cfg = 16'h03FD;
        chk("R7 reserved zero", cfg_word, exp_cfg);
    endtask

    task automatic t_read_only;
        send(16'h9000 | 16'h0004);          // read-only, cfg source
        chk("R5 unchanged", cfg_word, exp_cfg);
        chk("R5 rd_vld", {15'd0, rd_vld}, 16'd1);
        chk("R6 cfg readback", rd_data, exp_cfg);
        send(16'hB000);                     // read-only, gp source
        chk("R6 gp readback", rd_data, 16'h5A3C);
        chk("R5 unchanged gp", cfg_word, exp_cfg);
    endtask

    task automatic t_bad_addr;
        send(16'h4000 | 16'h0001);
        chk("R2 addr 01 no write", cfg_word, exp_cfg);
        chk("R2 addr 01 no rd", {15'd0, rd_vld}, 16'd0);
        send(16'hC000);
        chk("R2 addr 11 no write", cfg_word, exp_cfg);
        send(16'h0000);
        chk("R2 addr 00 no rd", {15'd0, rd_vld}, 16'd0);
    endtask

    task automatic t_bad_mode;
        mode = 3'd3;
        send(16'h8000);
        chk("R3 sleep no write", cfg_word, exp_cfg);
        chk("R3 sleep no rd", {15'd0, rd_vld}, 16'd0);
        mode = 3'd5;
        send(16'h8000);
        chk("R3 code5 no write", cfg_word, exp_cfg);
        mode = 3'd1;
    endtask

    task automatic t_reset_entry;
        mode = 3'd1;
        send(16'h80C0);                     // rlen 0, sup 11
        exp_cfg = 16'h00C0;
        chk("R8 rlen cleared by write", cfg_word, exp_cfg);
        @(negedge clk);
        mode = 3'd0;
        @(negedge clk);
        chk("R8 rlen set on reset entry", {15'd0, rst_len_long}, 16'd1);
        send(16'h8000);
        exp_cfg = 16'h01C0;
        chk("R3 reset mode no write", cfg_word, exp_cfg);
        mode = 3'd1;
    endtask

    task automatic t_sup_clear;
        send(16'h80C0);
        @(negedge clk);
        mode = 3'd4;
        @(negedge clk);
        mode = 3'd1;
        chk("R9 failsafe clears", cfg_word, 16'h0000);
        send(16'h80C8);
        @(negedge clk);
        rstpin_fall = 1'b1;
        @(negedge clk);
        rstpin_fall = 1'b0;
        chk("R9 pin fall clears", cfg_word, 16'h0008);
        send(16'h80C8);
        @(negedge clk);
        sup_short = 1'b1;
        @(negedge clk);
        sup_short = 1'b0;
        chk("R9 short clears", cfg_word, 16'h0008);
    endtask

    task automatic t_collision;
        send(16'h8004);
        @(negedge clk);
        frm_vld = 1'b1; frm_data = 16'h83FD; sup_short = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0; frm_data = '0; sup_short = 1'b0;
        chk("R9 short wins over write", cfg_word, 16'h033D);
        chk("R6 collision readback", rd_data, 16'h0004);
        @(negedge clk);
        frm_vld = 1'b1; frm_data = 16'h82C1; rstpin_fall = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0; frm_data = '0; rstpin_fall = 1'b0;
        chk("R9 pin fall wins over write", cfg_word, 16'h0201);
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_reserved();
        t_read_only();
        t_bad_addr();
        t_bad_mode();
        t_reset_entry();
        t_sup_clear();
        t_collision();
        finish_run();
    end

endmodule